// File: doc/BRIEF.md
# Temperature Sensor Bring-up Sequencer

This block sits in front of a byte-level two-wire (I2C) master. It drives the master's command side: enable, slave address, read/write select and write byte. It watches the master's busy and acknowledge-error outputs and its read byte. Out of reset it runs a fixed script against a temperature sensor at slave address 1001000.

The script has three transactions, each framed by START and STOP. The first writes pointer 0x01 and then 0x60, which puts the sensor into 12-bit conversion mode. The second writes pointer 0x00 so that later reads return the temperature register. The third reads two bytes, high byte first. The block then presents the 12-bit temperature and a single-cycle valid pulse.

The master takes a byte and opens its acknowledge window, and at that moment its busy output drops. The sequencer treats each falling edge of busy as the signal to give the next byte or to release enable. When a slave fails to acknowledge, the run aborts and an error flag is raised. After a completed run or an abort, the block stays quiet until the restart input is pulsed.

Top module: `sensor_seq_top`

## Requirements
- R1: While reset is asserted, ena, tempValid and errFlag are all low.
- R2: One cycle after reset is released, ena goes high with addr = 7'b1001000, rnw = 0 and dataWr = 0x01. A pointer byte's two LSBs select a register: 00 temperature, 01 configuration, 10 low threshold, 11 high threshold.
- R3: In the first transaction, the cycle after the first busy falling edge, ena is still high and dataWr is 0x60.
- R4: The cycle after the busy falling edge that ends a transaction's last byte, ena is low. It stays low until the next busy falling edge, which marks the end of STOP.
- R5: The second transaction presents rnw = 0 and dataWr = 0x00, and carries exactly one byte after the address.
- R6: The third transaction presents rnw = 1. ena stays high after the first byte is taken and drops after the second. rnw does not change while ena stays high.
- R7: The byte on dataRd at the first read busy fall is the high byte (H). The byte at the second read busy fall is the low byte (L). temp becomes bits 15..4 of {H, L}, and tempValid is high for exactly one cycle, in the cycle after the second fall.
- R8: An ackError seen while a transaction is active sets errFlag and drops ena. ena then stays low, whatever busy does, until restart.
- R9: A restart pulse while the block is finished or aborted clears errFlag and starts the script again from the first transaction.
- R10: A restart pulse while a transaction is in progress has no effect on the script.
- R11: While ena is high, dataWr does not change except in the cycle after a busy falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Single-cycle request to rerun the script when idle |
| ena | output | 1 | Command enable to the master |
| addr | output | 7 | Slave address to the master |
| rnw | output | 1 | Read (1) or write (0) select |
| dataWr | output | 8 | Byte for the master to write |
| busy | input | 1 | Master busy; its falling edge means the byte has been taken |
| dataRd | input | 8 | Byte read by the master |
| ackError | input | 1 | Master saw no acknowledge from the slave |
| temp | output | 12 | Last temperature result |
| tempValid | output | 1 | One-cycle strobe for a new temp |
| errFlag | output | 1 | Sticky abort flag, cleared by restart |

## Verification
Some properties are checked on every cycle by assertions:
- ena drops after a last byte.
- rnw and dataWr are stable while ena is held.
- tempValid never lasts two cycles.
- ena stays low while errFlag is set.

Other behaviour only the directed scenarios can show, because it depends on the script's content and order:
- the exact pointer and configuration byte values in each transaction;
- that the high byte comes first in the result;
- that restart is ignored mid-run but takes effect after completion or an abort.

// File: rtl/sensor_seq_pkg.sv
`timescale 1ns/1ps
package sensor_seq_pkg;

  typedef enum logic [2:0] {
    S_BOOT,
    S_ISSUE,
    S_STOP,
    S_DONE,
    S_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capMsb;
    logic capLsb;
    logic setErr;
    logic clrErr;
  } seqStrobe_t;

endpackage

// File: rtl/sensor_seq_ctrl.sv
`timescale 1ns/1ps
module sensor_seq_ctrl
  import sensor_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  CFG_PTR  = 8'h01,
  parameter logic [7:0]  CFG_VAL  = 8'h60,
  parameter logic [7:0]  TEMP_PTR = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              busyFall,
  input  logic              ackError,
  output logic              ena,
  output logic              rnw,
  output logic [DATA_W-1:0] dataWr,
  output seqStrobe_t        strobe
);

  localparam int          NUM_TXN  = 3;
  localparam int          TXN_W    = $clog2(NUM_TXN);
  localparam logic [TXN_W-1:0] TXN_CFG  = TXN_W'(0);
  localparam logic [TXN_W-1:0] TXN_PTR  = TXN_W'(1);
  localparam logic [TXN_W-1:0] TXN_READ = TXN_W'(NUM_TXN - 1);

  seqState_t        state;
  logic [TXN_W-1:0] txnIdx;
  logic             byteIdx;
  logic             lastByte;

  // the pointer-only transaction has one byte, the others two
  assign lastByte = (txnIdx == TXN_PTR) ? 1'b1 : byteIdx;

  always_comb begin
    dataWr = '0;
    case (txnIdx)
      TXN_CFG: dataWr = byteIdx ? DATA_W'(CFG_VAL) : DATA_W'(CFG_PTR);
      TXN_PTR: dataWr = DATA_W'(TEMP_PTR);
      default: dataWr = '0;
    endcase
  end

  assign rnw = (txnIdx == TXN_READ);
  assign ena = (state == S_ISSUE);

  always_comb begin
    strobe        = '0;
    strobe.capMsb = (state == S_ISSUE) && busyFall && !ackError && rnw && !byteIdx;
    strobe.capLsb = (state == S_ISSUE) && busyFall && !ackError && rnw && byteIdx;
    strobe.setErr = ((state == S_ISSUE) || (state == S_STOP)) && ackError;
    strobe.clrErr = ((state == S_DONE) || (state == S_FAULT)) && restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_BOOT;
      txnIdx  <= '0;
      byteIdx <= 1'b0;
    end else begin
      case (state)
        S_BOOT: begin
          state   <= S_ISSUE;
          txnIdx  <= TXN_CFG;
          byteIdx <= 1'b0;
        end
        S_ISSUE: begin
          if (ackError) state <= S_FAULT;
          else if (busyFall) begin
            if (lastByte) state <= S_STOP;
            else          byteIdx <= 1'b1;
          end
        end
        S_STOP: begin
          if (ackError) state <= S_FAULT;
          else if (busyFall) begin
            byteIdx <= 1'b0;
            if (txnIdx == TXN_READ) state <= S_DONE;
            else begin
              txnIdx <= txnIdx + 1'b1;
              state  <= S_ISSUE;
            end
          end
        end
        default: begin
          if (restart) begin
            state   <= S_ISSUE;
            txnIdx  <= TXN_CFG;
            byteIdx <= 1'b0;
          end
        end
      endcase
    end
  end

  // R4: enable released right after the last byte is taken
  p_ena_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ena && busyFall && lastByte && !ackError) |=> !ena);

  // R6: direction never changes while a command is held
  p_rnw_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ena && $past(ena)) |-> $stable(rnw));

  // R11: write byte only moves after the master took the previous one
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ena && $past(ena) && !$past(busyFall)) |-> $stable(dataWr));

endmodule

// File: rtl/sensor_seq_dp.sv
`timescale 1ns/1ps
module sensor_seq_dp
  import sensor_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic [DATA_W-1:0] dataRd,
  input  seqStrobe_t        strobe,
  output logic              busyFall,
  output logic [TEMP_W-1:0] temp,
  output logic              tempValid,
  output logic              errFlag
);

  localparam int PAIR_W = 2 * DATA_W;

  logic              busyQ;
  logic [DATA_W-1:0] msbReg;
  logic [PAIR_W-1:0] pair;

  assign busyFall = busyQ && !busy;
  assign pair     = {msbReg, dataRd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      msbReg    <= '0;
      temp      <= '0;
      tempValid <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      busyQ     <= busy;
      tempValid <= strobe.capLsb;
      if (strobe.capMsb) msbReg <= dataRd;
      if (strobe.capLsb) temp   <= pair[PAIR_W-1 -: TEMP_W];
      if (strobe.setErr)      errFlag <= 1'b1;
      else if (strobe.clrErr) errFlag <= 1'b0;
    end
  end

  // R7: result strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    tempValid |=> !tempValid);

endmodule

// File: rtl/sensor_seq_top.sv
`timescale 1ns/1ps
module sensor_seq_top
  import sensor_seq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 7,
  parameter int          TEMP_W     = 12,
  parameter logic [6:0]  SLAVE_ADDR = 7'b1001000,
  parameter logic [7:0]  CFG_PTR    = 8'h01,
  parameter logic [7:0]  CFG_VAL    = 8'h60,
  parameter logic [7:0]  TEMP_PTR   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  output logic              ena,
  output logic [ADDR_W-1:0] addr,
  output logic              rnw,
  output logic [DATA_W-1:0] dataWr,
  input  logic              busy,
  input  logic [DATA_W-1:0] dataRd,
  input  logic              ackError,
  output logic [TEMP_W-1:0] temp,
  output logic              tempValid,
  output logic              errFlag
);

  seqStrobe_t strobe;
  logic       busyFall;

  assign addr = ADDR_W'(SLAVE_ADDR);

  sensor_seq_ctrl #(
    .DATA_W(DATA_W), .CFG_PTR(CFG_PTR), .CFG_VAL(CFG_VAL), .TEMP_PTR(TEMP_PTR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .busyFall(busyFall),
    .ackError(ackError), .ena(ena), .rnw(rnw), .dataWr(dataWr), .strobe(strobe)
  );

  sensor_seq_dp #(
    .DATA_W(DATA_W), .TEMP_W(TEMP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .dataRd(dataRd), .strobe(strobe),
    .busyFall(busyFall), .temp(temp), .tempValid(tempValid), .errFlag(errFlag)
  );

  // R8: no command is issued while the abort flag stands
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !ena);

endmodule

// File: tb/sensor_seq_top_test.sv
`timescale 1ns/1ps
module sensor_seq_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        restart = 1'b0;
  logic        busy = 1'b0;
  logic [7:0]  dataRd = 8'h00;
  logic        ackError = 1'b0;
  logic        ena;
  logic [6:0]  addr;
  logic        rnw;
  logic [7:0]  dataWr;
  logic [11:0] temp;
  logic        tempValid;
  logic        errFlag;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sensor_seq_top uut (
    .clk(clk), .rstN(rstN), .restart(restart), .ena(ena), .addr(addr),
    .rnw(rnw), .dataWr(dataWr), .busy(busy), .dataRd(dataRd),
    .ackError(ackError), .temp(temp), .tempValid(tempValid), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // master accepts a byte: busy high a few cycles, then falls
  task automatic byteCycle(input logic [7:0] rd, input bit nack);
    @(negedge clk);
    busy = 1'b1;
    if (nack) ackError = 1'b1;
    repeat (3) @(negedge clk);
    dataRd = rd;
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic stopCycle();
    byteCycle(8'h00, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ena", {15'd0, ena}, 16'd0);
    chk("R1 tempValid", {15'd0, tempValid}, 16'd0);
    chk("R1 errFlag", {15'd0, errFlag}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 ena", {15'd0, ena}, 16'd1);
    chk("R2 addr", {9'd0, addr}, 16'h0048);
    chk("R2 rnw", {15'd0, rnw}, 16'd0);
    chk("R2 dataWr", {8'd0, dataWr}, 16'h0001);
  endtask

  task automatic t_config();
    byteCycle(8'h00, 1'b0);
    chk("R3 ena", {15'd0, ena}, 16'd1);
    chk("R3 dataWr", {8'd0, dataWr}, 16'h0060);
    byteCycle(8'h00, 1'b0);
    chk("R4 ena dropped", {15'd0, ena}, 16'd0);
    repeat (3) @(negedge clk);
    chk("R4 ena held low", {15'd0, ena}, 16'd0);
    stopCycle();
    chk("R5 ena", {15'd0, ena}, 16'd1);
    chk("R5 rnw", {15'd0, rnw}, 16'd0);
    chk("R5 dataWr", {8'd0, dataWr}, 16'h0000);
  endtask

  task automatic t_pointer();
    // restart mid-run must be ignored
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    @(negedge clk);
    chk("R10 ena", {15'd0, ena}, 16'd1);
    chk("R10 dataWr", {8'd0, dataWr}, 16'h0000);
    byteCycle(8'h00, 1'b0);
    chk("R5 single byte", {15'd0, ena}, 16'd0);
    stopCycle();
    chk("R6 ena", {15'd0, ena}, 16'd1);
    chk("R6 rnw", {15'd0, rnw}, 16'd1);
  endtask

  task automatic t_read(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] pairExp;
    pairExp = {hi, lo};
    byteCycle(hi, 1'b0);
    chk("R6 ena after first", {15'd0, ena}, 16'd1);
    chk("R6 rnw held", {15'd0, rnw}, 16'd1);
    chk("R7 no early valid", {15'd0, tempValid}, 16'd0);
    byteCycle(lo, 1'b0);
    chk("R6 ena after second", {15'd0, ena}, 16'd0);
    chk("R7 valid", {15'd0, tempValid}, 16'd1);
    chk("R7 temp", {4'd0, temp}, {4'd0, pairExp[15:4]});
    @(negedge clk);
    chk("R7 valid one cycle", {15'd0, tempValid}, 16'd0);
    stopCycle();
    repeat (3) @(negedge clk);
    chk("R9 idle after run", {15'd0, ena}, 16'd0);
  endtask

  task automatic t_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9 ena", {15'd0, ena}, 16'd1);
    chk("R9 dataWr", {8'd0, dataWr}, 16'h0001);
  endtask

  task automatic t_error();
    byteCycle(8'h00, 1'b1);
    chk("R8 errFlag", {15'd0, errFlag}, 16'd1);
    chk("R8 ena", {15'd0, ena}, 16'd0);
    ackError = 1'b0;
    stopCycle();
    byteCycle(8'h00, 1'b0);
    chk("R8 still quiet", {15'd0, ena}, 16'd0);
    chk("R8 flag sticky", {15'd0, errFlag}, 16'd1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9 err cleared", {15'd0, errFlag}, 16'd0);
    chk("R9 rerun ena", {15'd0, ena}, 16'd1);
    chk("R9 rerun dataWr", {8'd0, dataWr}, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_config();
    t_pointer();
    t_read(8'hA5, 8'h3C);
    t_restart();
    t_error();
    t_config();
    t_pointer();
    t_read(8'h19, 8'hF0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule